// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block settles how many elements one pass of a strip-mined vector loop will handle. Software presents the number of elements it still has to process, an element-width code, a register-grouping code and two policy bits (tail and mask). The unit works out how many elements of that width fit into the selected register group, which is its capacity, and grants the smaller of that capacity and the request. The granted count goes back as a scalar result that the loop uses as its step. The unit also records the element width, grouping and policies so that later vector operations can read them.

The hardware register width is fixed when the block is built. The capacity is computed at run time from that width, the grouping factor and the element width, and the grouping factor may be a fraction. The width is a power of two and each factor is a power of two, so the whole calculation reduces to a shift. If a fractional grouping leaves less than one element, or if the grouping code is a reserved one, the configuration is marked illegal and the granted count is forced to zero.

Top module: `vl_cfg_unit`

## Requirements
- R1: With an integer grouping code (000=x1, 001=x2, 010=x4, 011=x8) and element-width code (00=8, 01=16, 10=32, 11=64 bits), `cap_out` equals VLEN_BITS times the factor divided by the element width.
- R2: Grouping code 110 selects one quarter and 111 selects one half. The capacity is divided by 4 or by 2 accordingly.
- R3: On a legal configuration `vl_out` equals the smaller of `req_avl` and the capacity, including requests of 0 and the all-ones request.
- R4: When a fractional grouping gives a capacity below one element, `cfg_illegal` is 1, and `vl_out` and `cap_out` are both 0.
- R5: Grouping codes 100 and 101 are reserved. They set `cfg_illegal` to 1 and give `vl_out` = 0 and `cap_out` = 0.
- R6: The results and `done` appear on the clock edge after the one on which `req_valid` is sampled high. `done` is high for exactly one cycle per accepted request.
- R7: On an accepted request, `cfg_sew`, `cfg_lmul`, `cfg_tail_agn` and `cfg_mask_agn` all take the request's values in the same cycle.
- R8: While `req_valid` is low, changes on the other request inputs have no effect: every output holds its value and `done` stays 0.
- R9: Synchronous active-high reset gives `done`=0, `vl_out`=0, `cap_out`=0, `cfg_illegal`=1, and all configuration fields 0.
- R10: With VLEN_BITS=256, a 32-bit element width, a x1 grouping and a request of 5, `cap_out` is 8 and `vl_out` is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_avl | input | AVL_W | Requested element count |
| req_sew | input | 2 | Element-width code |
| req_lmul | input | 3 | Grouping-factor code |
| req_tail_agn | input | 1 | Tail policy, 1 = agnostic |
| req_mask_agn | input | 1 | Mask policy, 1 = agnostic |
| done | output | 1 | One-cycle strobe: results updated |
| vl_out | output | AVL_W | Granted vector length |
| cap_out | output | $clog2(VLEN_BITS)+1 | Maximum element capacity |
| cfg_illegal | output | 1 | Current configuration is illegal |
| cfg_sew | output | 2 | Latched element-width code |
| cfg_lmul | output | 3 | Latched grouping code |
| cfg_tail_agn | output | 1 | Latched tail policy |
| cfg_mask_agn | output | 1 | Latched mask policy |

## Verification
Every result is registered once, so all outputs are due exactly one clock after the edge that samples a valid request, and they must hold through every idle cycle that follows. The bench model updates its expected values on the same edge the design does. It compares every output on the falling edge that follows, so each cycle is checked once the outputs have settled. Two instances with different register widths are driven with the same stimulus. This lets the capacity-below-one case appear on the narrower one while the wider one stays legal.

// File: rtl/vl_cfg_pkg.sv
package vl_cfg_pkg;

  typedef enum logic [1:0] {
    SEW_E8  = 2'b00,
    SEW_E16 = 2'b01,
    SEW_E32 = 2'b10,
    SEW_E64 = 2'b11
  } sew_code_e;

  typedef enum logic [2:0] {
    GRP_X1   = 3'b000,
    GRP_X2   = 3'b001,
    GRP_X4   = 3'b010,
    GRP_X8   = 3'b011,
    GRP_RSV4 = 3'b100,
    GRP_RSV5 = 3'b101,
    GRP_QTR  = 3'b110,
    GRP_HALF = 3'b111
  } grp_code_e;

  typedef struct packed {
    sew_code_e sew;
    grp_code_e grp;
    logic      tail_agn;
    logic      mask_agn;
  } vcfg_t;

  function automatic logic grp_reserved(input grp_code_e g);
    return (g == GRP_RSV4) || (g == GRP_RSV5);
  endfunction

endpackage

// File: rtl/vl_cap_calc.sv
module vl_cap_calc
  import vl_cfg_pkg::*;
#(
  parameter int VLEN_BITS = 256,
  parameter int CAP_W     = $clog2(VLEN_BITS) + 1
) (
  input  sew_code_e        sew,
  input  grp_code_e        grp,
  output logic [CAP_W-1:0] cap,
  output logic             bad
);
  localparam int LOGV = $clog2(VLEN_BITS);

  int expn;

  always_comb begin
    expn = LOGV - 3 - int'(sew);
    case (grp)
      GRP_QTR:  expn = expn - 2;
      GRP_HALF: expn = expn - 1;
      default:  expn = expn + int'(grp[1:0]);
    endcase
    cap = '0;
    bad = 1'b0;
    if (grp_reserved(grp) || expn < 0) begin
      bad = 1'b1;
    end else begin
      cap = CAP_W'(1) << expn;
    end
  end

endmodule

// File: rtl/vl_grant.sv
module vl_grant #(
  parameter int AVL_W = 32,
  parameter int CAP_W = 9
) (
  input  logic [AVL_W-1:0] avl,
  input  logic [CAP_W-1:0] cap,
  input  logic             force_zero,
  output logic [AVL_W-1:0] vl
);
  localparam int PAD = AVL_W - CAP_W;

  logic [AVL_W-1:0] cap_ext;

  always_comb begin
    cap_ext = {{PAD{1'b0}}, cap};
    if (force_zero)
      vl = '0;
    else if (avl < cap_ext)
      vl = avl;
    else
      vl = cap_ext;
  end

endmodule

// File: rtl/vl_cfg_unit.sv
module vl_cfg_unit
  import vl_cfg_pkg::*;
#(
  parameter int VLEN_BITS = 256,
  parameter int AVL_W     = 32,
  parameter int CAP_W     = $clog2(VLEN_BITS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AVL_W-1:0] req_avl,
  input  logic [1:0]       req_sew,
  input  logic [2:0]       req_lmul,
  input  logic             req_tail_agn,
  input  logic             req_mask_agn,
  output logic             done,
  output logic [AVL_W-1:0] vl_out,
  output logic [CAP_W-1:0] cap_out,
  output logic             cfg_illegal,
  output logic [1:0]       cfg_sew,
  output logic [2:0]       cfg_lmul,
  output logic             cfg_tail_agn,
  output logic             cfg_mask_agn
);

  vcfg_t            req_cfg;
  vcfg_t            cfg_q;
  logic [CAP_W-1:0] cap_nxt;
  logic             bad_nxt;
  logic [AVL_W-1:0] vl_nxt;

  assign req_cfg = '{sew: sew_code_e'(req_sew), grp: grp_code_e'(req_lmul),
                     tail_agn: req_tail_agn, mask_agn: req_mask_agn};

  vl_cap_calc #(.VLEN_BITS(VLEN_BITS), .CAP_W(CAP_W)) u_cap (
    .sew (req_cfg.sew),
    .grp (req_cfg.grp),
    .cap (cap_nxt),
    .bad (bad_nxt)
  );

  vl_grant #(.AVL_W(AVL_W), .CAP_W(CAP_W)) u_grant (
    .avl        (req_avl),
    .cap        (cap_nxt),
    .force_zero (bad_nxt),
    .vl         (vl_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      vl_out      <= '0;
      cap_out     <= '0;
      cfg_illegal <= 1'b1;
      cfg_q       <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        vl_out      <= vl_nxt;
        cap_out     <= cap_nxt;
        cfg_illegal <= bad_nxt;
        cfg_q       <= req_cfg;
      end
    end
  end

  assign cfg_sew      = cfg_q.sew;
  assign cfg_lmul     = cfg_q.grp;
  assign cfg_tail_agn = cfg_q.tail_agn;
  assign cfg_mask_agn = cfg_q.mask_agn;

endmodule

// File: rtl/vl_cfg_unit_chk.sv
module vl_cfg_unit_chk #(
  parameter int VLEN_BITS = 256,
  parameter int AVL_W     = 32,
  parameter int CAP_W     = $clog2(VLEN_BITS) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [AVL_W-1:0] req_avl,
  input logic [1:0]       req_sew,
  input logic [2:0]       req_lmul,
  input logic             req_tail_agn,
  input logic             req_mask_agn,
  input logic             done,
  input logic [AVL_W-1:0] vl_out,
  input logic [CAP_W-1:0] cap_out,
  input logic             cfg_illegal,
  input logic [1:0]       cfg_sew,
  input logic [2:0]       cfg_lmul,
  input logic             cfg_tail_agn,
  input logic             cfg_mask_agn
);

  // R1 / R2: capacity is always a power of two or zero
  p_cap_pow2_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cap_out));

  // R3: granted length is the minimum of request and capacity
  p_grant_min_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rst) |=> (cfg_illegal ||
      vl_out == (($past(req_avl) < AVL_W'(cap_out)) ? $past(req_avl) : AVL_W'(cap_out))));

  // R4: illegal configuration grants nothing
  p_illegal_zero_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_illegal |-> (vl_out == '0 && cap_out == '0));

  // R5: reserved grouping codes are flagged
  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lmul[2:1] == 2'b10) |=> cfg_illegal);

  // R6: done follows an accepted request by one clock
  p_done_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);

  // R7: configuration fields latched together
  p_cfg_latch_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (cfg_sew == $past(req_sew) && cfg_lmul == $past(req_lmul) &&
                   cfg_tail_agn == $past(req_tail_agn) &&
                   cfg_mask_agn == $past(req_mask_agn)));

  // R8: idle cycles change nothing
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!done && $stable(vl_out) && $stable(cap_out) &&
                    $stable(cfg_illegal) && $stable(cfg_sew) && $stable(cfg_lmul)));

  // R3: granted length never exceeds capacity
  p_vl_le_cap_r3: assert property (@(posedge clk) disable iff (rst)
    AVL_W'(cap_out) >= vl_out);

endmodule

bind vl_cfg_unit vl_cfg_unit_chk #(
  .VLEN_BITS(VLEN_BITS), .AVL_W(AVL_W), .CAP_W(CAP_W)
) u_chk (.*);

// File: tb/vl_cfg_unit_tb.sv
`timescale 1ns/1ps
module vl_cfg_unit_tb;
  localparam int AVL_W = 32;
  localparam int VA = 256;
  localparam int VB = 128;
  localparam int CA_W = $clog2(VA) + 1;
  localparam int CB_W = $clog2(VB) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AVL_W-1:0] req_avl = '0;
  logic [1:0] req_sew = '0;
  logic [2:0] req_lmul = '0;
  logic req_tail_agn = 1'b0;
  logic req_mask_agn = 1'b0;

  logic done_a, ill_a, tail_a, mask_a;
  logic [AVL_W-1:0] vl_a;
  logic [CA_W-1:0] cap_a;
  logic [1:0] sew_a;
  logic [2:0] lmul_a;
  logic done_b, ill_b, tail_b, mask_b;
  logic [AVL_W-1:0] vl_b;
  logic [CB_W-1:0] cap_b;
  logic [1:0] sew_b;
  logic [2:0] lmul_b;

  int n_checks = 0;
  int n_fails = 0;
  string cur_req = "R9";
  bit started = 0;

  // expected values
  bit e_done = 0;
  bit e_tail = 0, e_mask = 0;
  int e_sew = 0, e_lmul = 0;
  longint e_vl_a = 0, e_cap_a = 0, e_vl_b = 0, e_cap_b = 0;
  bit e_ill_a = 1, e_ill_b = 1;

  always #4 clk = ~clk;

  vl_cfg_unit #(.VLEN_BITS(VA), .AVL_W(AVL_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_avl(req_avl),
    .req_sew(req_sew), .req_lmul(req_lmul), .req_tail_agn(req_tail_agn),
    .req_mask_agn(req_mask_agn), .done(done_a), .vl_out(vl_a), .cap_out(cap_a),
    .cfg_illegal(ill_a), .cfg_sew(sew_a), .cfg_lmul(lmul_a),
    .cfg_tail_agn(tail_a), .cfg_mask_agn(mask_a));

  vl_cfg_unit #(.VLEN_BITS(VB), .AVL_W(AVL_W)) u_dut_n128 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_avl(req_avl),
    .req_sew(req_sew), .req_lmul(req_lmul), .req_tail_agn(req_tail_agn),
    .req_mask_agn(req_mask_agn), .done(done_b), .vl_out(vl_b), .cap_out(cap_b),
    .cfg_illegal(ill_b), .cfg_sew(sew_b), .cfg_lmul(lmul_b),
    .cfg_tail_agn(tail_b), .cfg_mask_agn(mask_b));

  // capacity from the arithmetic definition; 0 means illegal
  function automatic longint cap_of(input int vlen, input int s, input int l);
    int num, den, elem;
    elem = 8 << s;
    num = 1; den = 1;
    case (l)
      0, 1, 2, 3: num = 1 << l;
      6: den = 4;
      7: den = 2;
      default: return 0;
    endcase
    return longint'((vlen * num) / (elem * den));
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      e_done = 0; e_vl_a = 0; e_cap_a = 0; e_vl_b = 0; e_cap_b = 0;
      e_ill_a = 1; e_ill_b = 1; e_sew = 0; e_lmul = 0; e_tail = 0; e_mask = 0;
    end else begin
      e_done = req_valid;
      if (req_valid) begin
        longint av;
        av = longint'(req_avl);
        e_cap_a = cap_of(VA, int'(req_sew), int'(req_lmul));
        e_cap_b = cap_of(VB, int'(req_sew), int'(req_lmul));
        e_ill_a = (e_cap_a == 0);
        e_ill_b = (e_cap_b == 0);
        e_vl_a = (av < e_cap_a) ? av : e_cap_a;
        e_vl_b = (av < e_cap_b) ? av : e_cap_b;
        e_sew = int'(req_sew); e_lmul = int'(req_lmul);
        e_tail = req_tail_agn; e_mask = req_mask_agn;
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R6 done a", longint'(done_a), longint'(e_done));
      chk("R6 done b", longint'(done_b), longint'(e_done));
      chk({cur_req, " vl a"}, longint'(vl_a), e_vl_a);
      chk({cur_req, " cap a"}, longint'(cap_a), e_cap_a);
      chk({cur_req, " illegal a"}, longint'(ill_a), longint'(e_ill_a));
      chk({cur_req, " vl b"}, longint'(vl_b), e_vl_b);
      chk({cur_req, " cap b"}, longint'(cap_b), e_cap_b);
      chk({cur_req, " illegal b"}, longint'(ill_b), longint'(e_ill_b));
      chk("R7 sew", longint'(sew_a), longint'(e_sew));
      chk("R7 lmul", longint'(lmul_b), longint'(e_lmul));
      chk("R7 tail", longint'(tail_a), longint'(e_tail));
      chk("R7 mask", longint'(mask_b), longint'(e_mask));
    end
  end

  task automatic req(input int s, input int l, input longint unsigned a,
                     input bit t, input bit m);
    @(negedge clk);
    req_valid = 1'b1; req_sew = 2'(s); req_lmul = 3'(l);
    req_avl = AVL_W'(a); req_tail_agn = t; req_mask_agn = m;
  endtask

  task automatic idle(input int k);
    string keep;
    keep = cur_req;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cur_req = "R8";
      req_valid = 1'b0;
      req_sew = ~req_sew; req_lmul = req_lmul + 3'd3;
      req_avl = req_avl ^ 32'h0000_00A5;
      req_tail_agn = ~req_tail_agn; req_mask_agn = ~req_mask_agn;
    end
    cur_req = keep;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    cur_req = "R9";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_req = "R10";
    req(2, 0, 5, 1, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 cap", longint'(cap_a), 8);
    chk("R10 vl", longint'(vl_a), 5);
    idle(1);

    cur_req = "R1";
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 4; l++) begin
        req(s, l, 5000, s[0], l[0]);
        idle(1);
      end

    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      req(s, 6, 5000, 1, 1);
      req(s, 7, 5000, 0, 1);
      idle(1);
    end

    cur_req = "R3";
    req(2, 0, 0, 0, 0);
    req(2, 0, 1, 1, 0);
    req(2, 0, 7, 0, 1);
    req(2, 0, 8, 1, 1);
    req(2, 0, 9, 0, 0);
    req(0, 3, 255, 1, 0);
    req(0, 3, 256, 0, 1);
    req(1, 1, 32'hFFFF_FFFF, 1, 1);
    idle(2);

    cur_req = "R4";
    req(3, 6, 40, 1, 0);
    idle(1);
    req(3, 7, 40, 0, 1);
    req(2, 6, 3, 1, 1);
    idle(1);

    cur_req = "R5";
    req(1, 4, 12, 0, 0);
    idle(1);
    req(2, 5, 12, 1, 1);
    req(0, 0, 12, 0, 1);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule